// File: doc/BRIEF.md
# Microcoded Reliability Accumulator

This block turns a set of buffered per-component error counts into a single system failure estimate held in an accumulator, the reliability register. Each count is a failure probability in units of 1/n for one observation window. A short program held in a small writable microcode store is stepped through one word per clock. Each word picks an operand, either one of the counter inputs or one of a few temporary registers, and an operation that combines it with the accumulator. Components in series are summed, redundant components are multiplied and then rescaled by a right shift, and a weighted choice among a power-of-two number of alternatives is averaged with a final shift.

Software or a boot sequencer fills the microcode store while the block is idle. A start strobe clears the accumulator and runs the program from address 0. The counter buffer stays stable for the run while the live error counters keep counting the next window. When the program ends the block pulses done for one cycle and holds the result until the next start. Addition and multiplication saturate at full scale. The shift never turns a nonzero value into zero, so a small but real failure probability is never lost.

Top module: `rel_accum`

## Requirements
- R1: After reset busy_o, done_o and acc_o are 0. A start_i seen while idle clears acc_o to 0 and raises busy_o at the next edge. The word at address 0 executes at the following edge, one word per cycle after that, so a program whose end word is at index L-1 raises done_o L cycles after busy_o rises.
- R2: Word layout: bits [2:0] opcode, bit [3] source (0 = counter input, 1 = temporary register), bits [5:4] operand index, bits [9:6] shift amount. Counter k is cnt_i[12k+11:12k]. Opcode 0 (load) puts the selected operand into the accumulator.
- R3: Opcode 1 (add) sets the accumulator to accumulator plus operand, saturating at full scale 4095.
- R4: Opcode 2 (multiply) sets the accumulator to accumulator times operand, saturating at 4095.
- R5: Opcode 3 (shift) shifts the accumulator right by the shift field. The result is at least 1 when the accumulator was nonzero, and 0 stays 0.
- R6: Opcode 4 (store) copies the accumulator into the temporary register named by the index field and leaves the accumulator unchanged. The stored value can later be used as an operand with source 1.
- R7: Opcode 5 (end) stops the run: busy_o falls and done_o is high for exactly one cycle. acc_o then holds its value until the next start, whatever cnt_i does. A start_i seen while busy is ignored.
- R8: uc_we_i writes uc_wdata_i to address uc_addr_i only while idle. A write attempted while busy has no effect on the program.
- R9: Opcodes 6 and 7 leave the accumulator unchanged. A run that executes the last address (15) without meeting an end word finishes there, as an end word would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, acted on only while idle |
| cnt_i | input | 48 | Buffered error counts, 4 fields of 12 bits |
| uc_we_i | input | 1 | Microcode store write enable |
| uc_addr_i | input | 4 | Microcode store write address |
| uc_wdata_i | input | 10 | Microcode word to write |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| acc_o | output | 12 | Reliability register |

## Verification
The programs tried are a pure series sum, a parallel product whose rescale underflows and then adds a series term, products and sums that exceed full scale, two independent subtrees joined through temporary spills, a weighted average with no-op words mixed in, and zero operands through multiply and shift. Each of these separates one fault: a wrapping adder or multiplier, a shift that loses a small nonzero value, a store that disturbs the accumulator, or the wrong temporary being read. Directed runs check when done appears against the length of the program. They also check that a start or a store write made mid-run leaves both the result and the timing unchanged, and that a program with no end word stops at the last address.

// File: rtl/rel_pkg.sv
package rel_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_ADD   = 3'd1,
        OP_MUL   = 3'd2,
        OP_SHR   = 3'd3,
        OP_STORE = 3'd4,
        OP_END   = 3'd5,
        OP_NOP6  = 3'd6,
        OP_NOP7  = 3'd7
    } op_e;
endpackage

// File: rtl/rel_ustore.sv
module rel_ustore #(
    parameter int DEPTH = 16,
    parameter int UW    = 10,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [UW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [UW-1:0] rdata_o
);
    localparam logic [UW-1:0] RST_WORD = UW'(rel_pkg::OP_END);

    logic [UW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_WORD;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rel_tmpfile.sv
module rel_tmpfile #(
    parameter int NUM_TMP = 2,
    parameter int DW      = 12,
    parameter int IDXW    = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            we_i,
    input  logic [IDXW-1:0] widx_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [IDXW-1:0] ridx_i,
    output logic [DW-1:0]   rdata_o
);
    logic [DW-1:0] tmp_q [NUM_TMP];

    for (genvar g = 0; g < NUM_TMP; g++) begin : g_tmp
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                tmp_q[g] <= '0;
            end else if (we_i && (widx_i == IDXW'(g))) begin
                tmp_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_TMP; i++) begin
            if (ridx_i == IDXW'(i)) rdata_o = tmp_q[i];
        end
    end
endmodule

// File: rtl/rel_alu.sv
module rel_alu #(
    parameter int DW  = 12,
    parameter int SHW = 4
) (
    input  rel_pkg::op_e     op_i,
    input  logic [DW-1:0]    acc_i,
    input  logic [DW-1:0]    opnd_i,
    input  logic [SHW-1:0]   shamt_i,
    output logic [DW-1:0]    res_o
);
    import rel_pkg::*;

    localparam logic [DW-1:0] FULL = '1;

    logic [DW:0]     sum;
    logic [2*DW-1:0] prod;
    logic [DW-1:0]   shr;

    assign sum  = {1'b0, acc_i} + {1'b0, opnd_i};
    assign prod = {{DW{1'b0}}, acc_i} * {{DW{1'b0}}, opnd_i};
    assign shr  = acc_i >> shamt_i;

    always_comb begin
        unique case (op_i)
            OP_LOAD: res_o = opnd_i;
            OP_ADD:  res_o = sum[DW] ? FULL : sum[DW-1:0];
            OP_MUL:  res_o = (|prod[2*DW-1:DW]) ? FULL : prod[DW-1:0];
            OP_SHR:  res_o = ((acc_i != '0) && (shr == '0)) ? DW'(1) : shr;
            default: res_o = acc_i;
        endcase
    end
endmodule

// File: rtl/rel_accum.sv
module rel_accum #(
    parameter int NUM_CNT = 4,
    parameter int NUM_TMP = 2,
    parameter int DW      = 12,
    parameter int UDEPTH  = 16,
    parameter int IDXW    = $clog2((NUM_CNT > NUM_TMP) ? NUM_CNT : NUM_TMP),
    parameter int SHW     = $clog2(DW),
    parameter int PCW     = $clog2(UDEPTH),
    parameter int UW      = 4 + IDXW + SHW
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [NUM_CNT*DW-1:0] cnt_i,
    input  logic                  uc_we_i,
    input  logic [PCW-1:0]        uc_addr_i,
    input  logic [UW-1:0]         uc_wdata_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [DW-1:0]         acc_o
);
    import rel_pkg::*;

    localparam int            IDX_LSB = 4;
    localparam int            SH_LSB  = IDX_LSB + IDXW;
    localparam logic [PCW-1:0] PC_LAST = PCW'(UDEPTH - 1);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [PCW-1:0] pc;
        logic [DW-1:0]  acc;
    } st_t;

    st_t s_d, s_q;

    logic [UW-1:0]   instr;
    op_e             op;
    logic            src_tmp;
    logic [IDXW-1:0] idx;
    logic [SHW-1:0]  shamt;
    logic [DW-1:0]   cnt_sel;
    logic [DW-1:0]   tmp_rd;
    logic [DW-1:0]   opnd;
    logic [DW-1:0]   alu_res;
    logic            tmp_we;

    rel_ustore #(.DEPTH(UDEPTH), .UW(UW), .AW(PCW)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (uc_we_i && !s_q.busy),
        .waddr_i (uc_addr_i),
        .wdata_i (uc_wdata_i),
        .raddr_i (s_q.pc),
        .rdata_o (instr)
    );

    assign op      = op_e'(instr[2:0]);
    assign src_tmp = instr[3];
    assign idx     = instr[IDX_LSB +: IDXW];
    assign shamt   = instr[SH_LSB +: SHW];

    always_comb begin
        cnt_sel = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (idx == IDXW'(i)) cnt_sel = cnt_i[i*DW +: DW];
        end
    end

    rel_tmpfile #(.NUM_TMP(NUM_TMP), .DW(DW), .IDXW(IDXW)) u_tmp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (tmp_we),
        .widx_i  (idx),
        .wdata_i (s_q.acc),
        .ridx_i  (idx),
        .rdata_o (tmp_rd)
    );

    assign opnd = src_tmp ? tmp_rd : cnt_sel;

    rel_alu #(.DW(DW), .SHW(SHW)) u_alu (
        .op_i    (op),
        .acc_i   (s_q.acc),
        .opnd_i  (opnd),
        .shamt_i (shamt),
        .res_o   (alu_res)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmp_we   = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy = 1'b1;
                s_d.pc   = '0;
                s_d.acc  = '0;
            end
        end else begin
            s_d.acc = alu_res;
            tmp_we  = (op == OP_STORE);
            if ((op == OP_END) || (s_q.pc == PC_LAST)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.pc = s_q.pc + PCW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign acc_o  = s_q.acc;
endmodule

// File: rtl/rel_accum_chk.sv
module rel_accum_chk #(
    parameter int DW = 12
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [DW-1:0] acc_o,
    input rel_pkg::op_e  op,
    input logic [DW-1:0] opnd,
    input logic [DW-1:0] alu_res
);
    import rel_pkg::*;

    assert_start_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && (acc_o == '0)));

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (op == OP_ADD)) |-> ((alu_res >= acc_o) && (alu_res >= opnd)));

    assert_mul_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (op == OP_MUL) && (opnd != '0)) |-> (alu_res >= acc_o));

    assert_shift_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (op == OP_SHR) && (acc_o != '0)) |-> ((alu_res != '0) && (alu_res <= acc_o)));

    assert_store_keeps_acc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && (op == OP_STORE)) |=> $stable(acc_o));

    assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> $stable(acc_o));

    assert_nop_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && ((op == OP_NOP6) || (op == OP_NOP7))) |=> $stable(acc_o));
endmodule

bind rel_accum rel_accum_chk #(.DW(DW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .acc_o   (acc_o),
    .op      (op),
    .opnd    (opnd),
    .alu_res (alu_res)
);

// File: tb/tb_rel_accum.sv
`timescale 1ns/1ps
module tb_rel_accum;
    localparam int NV = 9;

    function automatic logic [9:0] ins(input logic [2:0] op, input logic src,
                                       input logic [1:0] idx, input logic [3:0] sh);
        return {sh, idx, src, op};
    endfunction

    typedef struct packed {
        logic [0:9][9:0]  prog;
        logic [0:3][11:0] cnt;
        logic [11:0]      exp;
        logic [4:0]       len;
    } vec_t;

    localparam logic [9:0] E = 10'd5;

    localparam vec_t VEC [NV] = '{
        '{prog: '{ins(0,0,0,0), ins(2,0,1,0), ins(3,0,0,8), ins(1,0,2,0), E, E, E, E, E, E},
          cnt: '{12'd5, 12'd6, 12'd3, 12'd0}, exp: 12'd4, len: 5'd5},
        '{prog: '{ins(0,0,0,0), ins(1,0,1,0), ins(1,0,2,0), E, E, E, E, E, E, E},
          cnt: '{12'd100, 12'd200, 12'd300, 12'd0}, exp: 12'd600, len: 5'd4},
        '{prog: '{ins(0,0,0,0), ins(1,0,1,0), E, E, E, E, E, E, E, E},
          cnt: '{12'd4000, 12'd500, 12'd0, 12'd0}, exp: 12'd4095, len: 5'd3},
        '{prog: '{ins(0,0,0,0), ins(2,0,1,0), ins(3,0,0,8), E, E, E, E, E, E, E},
          cnt: '{12'd100, 12'd100, 12'd0, 12'd0}, exp: 12'd15, len: 5'd4},
        '{prog: '{ins(0,0,0,0), ins(2,0,1,0), ins(3,0,0,8), ins(4,0,1,0), ins(0,0,2,0),
                  ins(2,0,3,0), ins(3,0,0,8), ins(1,1,1,0), E, E},
          cnt: '{12'd64, 12'd32, 12'd16, 12'd8}, exp: 12'd9, len: 5'd9},
        '{prog: '{ins(0,0,0,0), ins(1,0,1,0), ins(6,0,2,0), ins(1,0,3,0), ins(7,1,0,3),
                  ins(3,0,0,2), E, E, E, E},
          cnt: '{12'd40, 12'd24, 12'd0, 12'd8}, exp: 12'd18, len: 5'd7},
        '{prog: '{ins(0,0,2,0), ins(3,0,0,3), E, E, E, E, E, E, E, E},
          cnt: '{12'd9, 12'd9, 12'd0, 12'd9}, exp: 12'd0, len: 5'd3},
        '{prog: '{ins(0,0,0,0), ins(2,0,2,0), ins(3,0,0,1), E, E, E, E, E, E, E},
          cnt: '{12'd77, 12'd5, 12'd0, 12'd1}, exp: 12'd0, len: 5'd4},
        '{prog: '{ins(0,0,0,0), ins(4,0,0,0), ins(1,0,1,0), ins(4,0,1,0), ins(0,1,0,0),
                  ins(2,1,1,0), ins(3,0,0,4), ins(1,1,0,0), E, E},
          cnt: '{12'd10, 12'd20, 12'd0, 12'd0}, exp: 12'd28, len: 5'd9}
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R4 R5 R3 sticky shift after product";
            1: return "R2 R3 series sum";
            2: return "R3 add saturation";
            3: return "R4 multiply saturation then shift";
            4: return "R6 temp spill of subtree";
            5: return "R9 nop words in weighted average";
            6: return "R5 zero stays zero";
            7: return "R4 multiply by zero";
            default: return "R6 two temps as leaves";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] cnt = '0;
    logic        uc_we = 1'b0;
    logic [3:0]  uc_addr = '0;
    logic [9:0]  uc_wdata = '0;
    logic        busy, done;
    logic [11:0] acc;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rel_accum dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cnt_i(cnt),
        .uc_we_i(uc_we), .uc_addr_i(uc_addr), .uc_wdata_i(uc_wdata),
        .busy_o(busy), .done_o(done), .acc_o(acc)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [9:0] w);
        @(negedge clk);
        uc_we = 1'b1; uc_addr = 4'(a); uc_wdata = w;
        @(negedge clk);
        uc_we = 1'b0;
    endtask

    task automatic set_cnt(input logic [0:3][11:0] c);
        for (int k = 0; k < 4; k++) cnt[k*12 +: 12] = c[k];
    endtask

    // Pulses start; then counts cycles until done, optionally poking start or
    // a store write mid-run at cycle poke_at.
    task automatic run(input string tag, input int poke_at, input int poke_kind, output int n);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R1 busy after start"}, int'(busy), 1);
        check({tag, " R1 acc cleared"}, int'(acc), 0);
        n = 0;
        while (!done && n < 40) begin
            if (n == poke_at && poke_kind == 1) start = 1'b1;
            if (n == poke_at && poke_kind == 2) begin
                uc_we = 1'b1; uc_addr = 4'd8; uc_wdata = ins(0,0,0,0);
            end
            @(negedge clk);
            start = 1'b0;
            uc_we = 1'b0;
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        logic [11:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset acc", int'(acc), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            for (int a = 0; a < 10; a++) wr(a, VEC[v].prog[a]);
            set_cnt(VEC[v].cnt);
            run(vtag(v), -1, 0, n);
            check({vtag(v), " result"}, int'(acc), int'(VEC[v].exp));
            check({vtag(v), " R1 cycles to done"}, n, int'(VEC[v].len));
        end

        // R7: done lasts one cycle, result held while counters change
        held = acc;
        @(negedge clk);
        check("R7 done one cycle", int'(done), 0);
        cnt = 48'hFFF_FFF_FFF_FFF;
        repeat (5) @(negedge clk);
        check("R7 acc held while idle", int'(acc), int'(held));
        check("R7 busy low after end", int'(busy), 0);

        // R7: start while busy ignored
        for (int a = 0; a < 10; a++) wr(a, VEC[4].prog[a]);
        set_cnt(VEC[4].cnt);
        run("R7 start mid-run", 3, 1, n);
        check("R7 start mid-run result", int'(acc), 9);
        check("R7 start mid-run cycles", n, 9);
        @(negedge clk);
        check("R7 no restart after mid-run start", int'(busy), 0);

        // R8: write while busy ignored
        run("R8 write mid-run", 2, 2, n);
        check("R8 write mid-run result", int'(acc), 9);
        check("R8 write mid-run cycles", n, 9);

        // R9: no end word, stop at last address
        wr(0, ins(0,0,0,0));
        for (int a = 1; a < 15; a++) wr(a, ins(((a % 2) == 1) ? 3'd6 : 3'd7, 0, 1, 0));
        wr(15, ins(1,0,1,0));
        set_cnt('{12'd3, 12'd4, 12'd0, 12'd0});
        run("R9 run off end", -1, 0, n);
        check("R9 run off end result", int'(acc), 7);
        check("R9 run off end cycles", n, 16);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule